// File: doc/BRIEF.md
# Dual-Channel Serial Converter Command Receiver

This block is the digital front end of a dual 10-bit converter. A host sends 16-bit command words over a three-wire link: an active-low select, a serial clock and a data line. The block samples the link in its own system clock domain and decodes the top two bits of each word. It then writes the 10-bit code into one of four places: the channel A latch, the channel B latch, a shared holding buffer, or a two-flag control register. The flags are a fast-speed flag and a power-down flag.

The holding buffer makes simultaneous updates possible. A write to channel A also copies the buffered code into channel B in the same cycle. A word is committed at its 16th bit, or earlier when select rises, in which case it is left-justified. After a full 16-bit word, the receiver stays closed until one extra rising serial-clock edge arrives. A transfer that starts before that edge is dropped.

Top module: `dac_cmd_rx`

## Requirements
- R1: After an asynchronous reset (rst_ni low), code_a_o, code_b_o, fast_o, pdown_o and the holding buffer are all zero.
- R2: A transfer begins when cs_ni falls. Data is sampled on each falling edge of sclk_i, most significant bit first. The 16th sampled bit commits the word. The code is taken from word bits 11:2, and the target from bits 15:14.
- R3: Target 2'b00 loads the code into both channel B (code_b_o) and the holding buffer. code_a_o does not change.
- R4: Target 2'b01 loads the code only into the holding buffer. code_a_o and code_b_o keep their values.
- R5: Target 2'b10 loads the code into code_a_o. In the same cycle, code_b_o takes the value the holding buffer had before the write.
- R6: Target 2'b11 sets fast_o from word bit 13 and pdown_o from word bit 12. Both channel codes keep their values.
- R7: If cs_ni rises after 1 to 15 sampled bits, the bits received so far are committed. They are placed at the top of the 16-bit word, with zeros below.
- R8: If cs_ni rises with no bit sampled, nothing is committed.
- R9: A word may be sent as two 8-bit bursts with a pause between them, inside one select-low period. After the 16th bit, further falling sclk_i edges are ignored until cs_ni rises.
- R10: After a 16-bit commit, the receiver ignores any transfer until it sees a rising sclk_i edge. A transfer whose cs_ni fall comes before that edge is dropped entirely.
- R11: The rearming rising sclk_i edge may occur while cs_ni is high. The next transfer is then accepted normally.
- R12: Word bits 1:0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; each sclk_i phase must last at least two periods |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low transfer select |
| sclk_i | input | 1 | Serial clock, data sampled on its falling edge |
| sdi_i | input | 1 | Serial data, most significant bit first |
| code_a_o | output | 10 | Channel A code |
| code_b_o | output | 10 | Channel B code |
| fast_o | output | 1 | Fast-speed flag from the control register |
| pdown_o | output | 1 | Power-down flag from the control register |

## Verification
The hardest situation to reach from the ports is a select fall that arrives while the receiver is still closed after a full word. A well-behaved host never produces it. The bench gets there by ending a 16-bit transfer with sclk_i held low, then toggling cs_ni high and low again and clocking a complete new word. The outputs must then show that the word was discarded. The cases of rearming with select high and of extra bits after the 16th are reached the same way, by shaping the sclk_i pulses around the select edges rather than by sending plain words.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;
  parameter int unsigned WORD_W_DEF = 16;
  parameter int unsigned CODE_W_DEF = 10;
  parameter int unsigned SYNC_DEF   = 2;

  typedef enum logic [1:0] {
    TGT_B    = 2'b00,
    TGT_BUF  = 2'b01,
    TGT_A    = 2'b10,
    TGT_CTRL = 2'b11
  } tgt_e;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_RECV = 2'd1,
    RX_LOCK = 2'd2,
    RX_HOLD = 2'd3
  } rx_state_e;
endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dac_rx_shift.sv
module dac_rx_shift
  import dac_rx_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_lvl_i,
  input  logic              cs_rise_i,
  input  logic              cs_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_i,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o,
  output rx_state_e         state_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] W_L = CNT_W'(WORD_W);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic [WORD_W-1:0] word_full, word_part;

  assign word_full = {sr_q[WORD_W-2:0], sdi_i};
  // partial word: received bits sit low in sr_q, move them to the top
  assign word_part = sr_q << (W_L - cnt_q);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sr_d     = sr_q;
    commit_o = 1'b0;
    word_o   = word_full;
    unique case (state_q)
      RX_IDLE: begin
        if (cs_fall_i) begin
          state_d = RX_RECV;
          cnt_d   = '0;
          sr_d    = '0;
        end
      end
      RX_RECV: begin
        if (cs_rise_i) begin
          state_d = RX_IDLE;
          if (cnt_q != '0) begin
            commit_o = 1'b1;
            word_o   = word_part;
          end
        end else if (sclk_fall_i) begin
          sr_d  = word_full;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == W_L - 1'b1) begin
            commit_o = 1'b1;
            state_d  = RX_LOCK;
          end
        end
      end
      RX_LOCK: begin
        if (sclk_rise_i) state_d = cs_lvl_i ? RX_IDLE : RX_HOLD;
      end
      RX_HOLD: begin
        if (cs_rise_i) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sr_q    <= sr_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/dac_rx_regs.sv
module dac_rx_regs
  import dac_rx_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned CODE_W = CODE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic [CODE_W-1:0] hold_o,
  output logic              fast_o,
  output logic              pdown_o
);
  localparam int unsigned FAST_BIT = WORD_W - 3;
  localparam int unsigned PD_BIT   = WORD_W - 4;
  localparam int unsigned CODE_LSB = WORD_W - 4 - CODE_W;

  tgt_e              tgt;
  logic [CODE_W-1:0] code;
  logic              unused_low;

  assign tgt        = tgt_e'(word_i[WORD_W-1 -: 2]);
  assign code       = word_i[CODE_LSB +: CODE_W];
  assign unused_low = ^word_i[CODE_LSB-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_a_o <= '0;
      code_b_o <= '0;
      hold_o   <= '0;
      fast_o   <= 1'b0;
      pdown_o  <= 1'b0;
    end else if (commit_i) begin
      unique case (tgt)
        TGT_B: begin
          code_b_o <= code;
          hold_o   <= code;
        end
        TGT_BUF: hold_o <= code;
        TGT_A: begin
          code_a_o <= code;
          code_b_o <= hold_o;
        end
        TGT_CTRL: begin
          fast_o  <= word_i[FAST_BIT];
          pdown_o <= word_i[PD_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
  import dac_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = WORD_W_DEF,
  parameter int unsigned CODE_W      = CODE_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              fast_o,
  output logic              pdown_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic [2:0]        pin_sync;
  logic              cs_lvl, sclk_lvl, sdi_lvl;
  logic [1:0]        lvl_q;
  logic              cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic              commit;
  logic [WORD_W-1:0] commit_word;
  rx_state_e         rx_state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CODE_W-1:0] hold_code;

  dac_rx_sync #(
    .N      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (pin_sync)
  );

  assign {cs_lvl, sclk_lvl, sdi_lvl} = pin_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 2'b10;
    else         lvl_q <= {cs_lvl, sclk_lvl};
  end

  assign cs_rise   =  cs_lvl   & ~lvl_q[1];
  assign cs_fall   = ~cs_lvl   &  lvl_q[1];
  assign sclk_rise =  sclk_lvl & ~lvl_q[0];
  assign sclk_fall = ~sclk_lvl &  lvl_q[0];

  dac_rx_shift #(.WORD_W(WORD_W)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_lvl_i   (cs_lvl),
    .cs_rise_i  (cs_rise),
    .cs_fall_i  (cs_fall),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .sdi_i      (sdi_lvl),
    .commit_o   (commit),
    .word_o     (commit_word),
    .state_o    (rx_state),
    .cnt_o      (bit_cnt)
  );

  dac_rx_regs #(.WORD_W(WORD_W), .CODE_W(CODE_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .word_i  (commit_word),
    .code_a_o(code_a_o),
    .code_b_o(code_b_o),
    .hold_o  (hold_code),
    .fast_o  (fast_o),
    .pdown_o (pdown_o)
  );
endmodule

// File: rtl/dac_rx_chk.sv
module dac_rx_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CODE_W = 10,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1),
  localparam int unsigned CODE_LSB = WORD_W - 4 - CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              commit_i,
  input logic [WORD_W-1:0] word_i,
  input logic [1:0]        state_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              sclk_fall_i,
  input logic [CODE_W-1:0] hold_i,
  input logic [CODE_W-1:0] code_a_i,
  input logic [CODE_W-1:0] code_b_i,
  input logic              fast_i,
  input logic              pdown_i
);
  logic [1:0]        tgt;
  logic [CODE_W-1:0] code;
  assign tgt  = word_i[WORD_W-1 -: 2];
  assign code = word_i[CODE_LSB +: CODE_W];

  assert_b_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && tgt == 2'b00 |=> code_b_i == $past(code) && hold_i == $past(code) && $stable(code_a_i));

  assert_buf_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && tgt == 2'b01 |=> $stable(code_a_i) && $stable(code_b_i));

  assert_a_only_on_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_a_i) |-> $past(commit_i && tgt == 2'b10));

  assert_b_from_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && tgt == 2'b10 |=> code_b_i == $past(hold_i));

  assert_ctrl_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({fast_i, pdown_i}) |-> $past(commit_i && tgt == 2'b11));

  assert_no_empty_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (cnt_i != '0 || sclk_fall_i));

  assert_commit_in_recv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> state_i == 2'd1);
endmodule

bind dac_cmd_rx dac_rx_chk #(.WORD_W(WORD_W), .CODE_W(CODE_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .commit_i   (commit),
  .word_i     (commit_word),
  .state_i    (rx_state),
  .cnt_i      (bit_cnt),
  .sclk_fall_i(sclk_fall),
  .hold_i     (hold_code),
  .code_a_i   (code_a_o),
  .code_b_i   (code_b_o),
  .fast_i     (fast_o),
  .pdown_i    (pdown_o)
);

// File: tb/test_dac_cmd_rx.sv
module test_dac_cmd_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [9:0] code_a, code_b;
  logic fast, pdown;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dac_cmd_rx i_dac_cmd_rx (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .code_a_o(code_a), .code_b_o(code_b), .fast_o(fast), .pdown_o(pdown)
  );

  // behavioural reference: two-cycle pin delay, then edge detect
  logic c0, c1, c2, k0, k1, k2, d0, d1, d2;
  int m_mode, m_a, m_b, m_hold, m_fast, m_pd;
  bit m_bits[$];

  task automatic m_commit();
    int w = 0;
    foreach (m_bits[i]) w = (w << 1) | int'(m_bits[i]);
    w = (w << (16 - m_bits.size())) & 16'hFFFF;
    case (w >> 14)
      0: begin m_b = (w >> 2) & 1023; m_hold = m_b; end
      1: m_hold = (w >> 2) & 1023;
      2: begin m_a = (w >> 2) & 1023; m_b = m_hold; end
      default: begin m_fast = (w >> 13) & 1; m_pd = (w >> 12) & 1; end
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0 = 1; c1 = 1; c2 = 1; k0 = 0; k1 = 0; k2 = 0; d0 = 0; d1 = 0; d2 = 0;
      m_mode = 0; m_a = 0; m_b = 0; m_hold = 0; m_fast = 0; m_pd = 0;
      m_bits.delete();
    end else begin
      case (m_mode)
        0: if (!c1 && c2) begin m_mode = 1; m_bits.delete(); end
        1: if (c1 && !c2) begin
             m_mode = 0;
             if (m_bits.size() > 0) m_commit();
           end else if (!k1 && k2) begin
             m_bits.push_back(d1);
             if (m_bits.size() == 16) begin m_commit(); m_mode = 2; end
           end
        2: if (k1 && !k2) m_mode = c1 ? 0 : 3;
        default: if (c1 && !c2) m_mode = 0;
      endcase
      c2 = c1; c1 = c0; c0 = cs_n;
      k2 = k1; k1 = k0; k0 = sclk;
      d2 = d1; d1 = d0; d0 = sdi;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_chk++;
      if (int'(code_a) != m_a) begin
        n_bad++; $display("FAIL R5 model code_a got=%0h exp=%0h", code_a, m_a);
      end
      if (int'(code_b) != m_b) begin
        n_bad++; $display("FAIL R3 model code_b got=%0h exp=%0h", code_b, m_b);
      end
      if (int'({fast, pdown}) != (m_fast * 2 + m_pd)) begin
        n_bad++; $display("FAIL R6 model flags got=%0b%0b exp=%0d%0d", fast, pdown, m_fast, m_pd);
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic chk_out(string tag, int a, int b, int f, int p);
    chk({tag, " code_a"}, int'(code_a), a);
    chk({tag, " code_b"}, int'(code_b), b);
    chk({tag, " fast"}, int'(fast), f);
    chk({tag, " pdown"}, int'(pdown), p);
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo(); cs_n = 1'b0; wt(4); endtask
  task automatic cs_hi(); cs_n = 1'b1; wt(4); endtask

  task automatic send_bits(logic [15:0] w, int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; sdi = w[15-i]; wt(4);
      sclk = 1'b0; wt(4);
    end
  endtask

  task automatic rearm(); sclk = 1'b1; wt(4); sclk = 1'b0; wt(4); endtask

  task automatic write_word(logic [15:0] w);
    cs_lo(); send_bits(w, 16); rearm(); cs_hi();
  endtask

  initial begin
    wt(3);
    chk_out("R1 reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    wt(4);
    chk_out("R1 after release", 0, 0, 0, 0);

    write_word(16'h8A94);                     // A <= 0x2A5
    chk_out("R2 R5 write A", 'h2A5, 0, 0, 0);
    write_word(16'h0554);                     // B <= 0x155
    chk_out("R3 write B", 'h2A5, 'h155, 0, 0);
    write_word(16'h4FFC);                     // buffer <= 0x3FF
    chk_out("R4 write buffer", 'h2A5, 'h155, 0, 0);
    write_word(16'h8004);                     // A <= 1, B <= buffer
    chk_out("R5 A with copy", 'h001, 'h3FF, 0, 0);
    write_word(16'hF000);
    chk_out("R6 ctrl 11", 'h001, 'h3FF, 1, 1);
    write_word(16'hE000);
    chk_out("R6 ctrl 10", 'h001, 'h3FF, 1, 0);
    write_word(16'h03C3);                     // B <= 0x0F0, low bits set
    chk_out("R12 low bits", 'h001, 'h0F0, 1, 0);

    cs_lo(); send_bits(16'h9ABC, 12); cs_hi(); // commits 0x9AB0
    chk_out("R7 partial", 'h2AC, 'h0F0, 1, 0);
    cs_lo(); cs_hi();
    chk_out("R8 empty", 'h2AC, 'h0F0, 1, 0);

    cs_lo(); send_bits(16'h0330, 8); wt(20);
    send_bits(16'h3000, 8); rearm(); cs_hi();
    chk_out("R9 two bytes", 'h2AC, 'h0CC, 1, 0);
    cs_lo(); send_bits(16'h8444, 16); send_bits(16'hFF00, 8); cs_hi();
    chk_out("R9 extra bits", 'h111, 'h0CC, 1, 0);

    cs_lo(); send_bits(16'h0888, 16); cs_hi();  // no rearm edge
    chk_out("R10 first word", 'h111, 'h222, 1, 0);
    cs_lo(); send_bits(16'h8FFC, 16); rearm(); cs_hi();
    chk_out("R10 dropped", 'h111, 'h222, 1, 0);

    cs_lo(); send_bits(16'h8140, 16); cs_hi(); rearm();
    chk_out("R11 A before", 'h050, 'h222, 1, 0);
    write_word(16'h0180);
    chk_out("R11 accepted", 'h050, 'h060, 1, 0);

    rst_n = 1'b0; wt(2);
    chk_out("R1 mid reset", 0, 0, 0, 0);
    rst_n = 1'b1; wt(4);
    write_word(16'h8000 | 16'h0FFC);
    chk_out("R2 full code", 'h3FF, 0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule